// File: doc/BRIEF.md
# Nibble-Pair DRAM Fetch Sequencer

This block reads display bytes from screen memory that is made of 4-bit-wide DRAM with a multiplexed address bus. Every fetch slot lasts eight clock phases. One row strobe opens the row that holds the byte. Two column strobes inside that open row then read nibble address 2n, which gives the upper half of the byte, and nibble address 2n+1, which gives the lower half. The sequencer joins the two halves into one byte. It also sends a one-cycle column-advance pulse, so that the address generator can move to the next screen column.

A fetch takes place only in a slot whose decision point finds three conditions true: the fetch window is open, no spacer line is active, and the rate divider is at zero. At full rate a fetch can happen in every slot. At half rate only every other slot is eligible. The byte address and the enables are sampled once, at the start of the slot, and any change to them later in the slot has no effect on it. In a slot with no fetch, the strobes stay high and the last byte is held.

Top module: `nibble_fetch_seq`

## Requirements
- R1: While reset is asserted, and at the first sample after it, `ras_n` and `cas_n` are 1, `col_adv` is 0, and `dram_addr` and `byte_out` are 0.
- R2: In a fetching slot, where edge E0 is the first edge of the slot and Ek the edge k phases later, `ras_n` is low after E1 through E6, `cas_n` is low after E2, E3, E5 and E6, and both strobes are high after E7.
- R3: After E0 of a fetching slot, `dram_addr` carries bits 15 to 7 of the byte address.
- R4: From E1 through E3, `dram_addr` is {addr[6:0],0}, zero-extended to 9 bits. From E4 through E7 it is {addr[6:0],1}. The address does not change on the edge where `cas_n` falls.
- R5: `byte_out` changes only at E6 of a fetching slot. It then becomes {nibble sampled at E3, nibble sampled at E6}, with the first nibble in bits 7:4.
- R6: `col_adv` is high for exactly the cycle after E6 of a fetching slot, while both strobes are low. It is never high in any other cycle.
- R7: The fetch decision, and the byte address used for the whole slot, are sampled at E0 only. A slot fetches when `fetch_win`=1, `spacer`=0 and the rate divider is 0. Input changes after E0 do not affect that slot.
- R8: `half_rate` is sampled at E7. With `half_rate`=0 every slot is eligible. With `half_rate`=1 the eligibility alternates, and the first slot after reset is eligible.
- R9: A slot that does not fetch keeps both strobes high, keeps `col_adv` at 0, and leaves `byte_out` unchanged.
- R10: `cas_n` is never low while `ras_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_addr | input | 16 | Screen byte address |
| fetch_win | input | 1 | Horizontal fetch window open |
| spacer | input | 1 | Spacer line active; suppresses fetch |
| half_rate | input | 1 | 1 = fetch on every other slot (40-byte lines) |
| dram_nibble | input | 4 | Data returned by the DRAM |
| dram_addr | output | 9 | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| byte_out | output | 8 | Assembled display byte |
| col_adv | output | 1 | Column-advance pulse to the address generator |

## Verification
The assertions assume that the DRAM model returns data in the cycle after a column strobe falls, and that `half_rate` does not change inside a slot. The stimulus changes `half_rate` only between slots. The bench's memory model latches the address that was present in the cycle before each strobe fell. Right after E0 the bench drives the inverse of the byte address and flips the enables, so that it can show these inputs are ignored within the slot.

// File: rtl/nibble_fetch_seq.sv
module nibble_fetch_seq #(
  parameter int ADDR_W = 16,
  parameter int COL_W  = 7,
  parameter int NIB_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       byte_addr,
  input  logic                    fetch_win,
  input  logic                    spacer,
  input  logic                    half_rate,
  input  logic [NIB_W-1:0]        dram_nibble,
  output logic [ADDR_W-COL_W-1:0] dram_addr,
  output logic                    ras_n,
  output logic                    cas_n,
  output logic [2*NIB_W-1:0]      byte_out,
  output logic                    col_adv
);
  localparam int ROW_W = ADDR_W - COL_W;

  logic [2:0]        ph;
  logic              slot;
  logic              fetch_q;
  logic [COL_W-1:0]  col_q;
  logic [NIB_W-1:0]  hi_q;

  wire go = ~slot & fetch_win & ~spacer;
  wire [ROW_W-1:0] row_a = byte_addr[ADDR_W-1:COL_W];
  wire [ROW_W-1:0] col0  = ROW_W'({col_q, 1'b0});
  wire [ROW_W-1:0] col1  = ROW_W'({col_q, 1'b1});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= '0;
      slot      <= 1'b0;
      fetch_q   <= 1'b0;
      col_q     <= '0;
      hi_q      <= '0;
      dram_addr <= '0;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      byte_out  <= '0;
      col_adv   <= 1'b0;
    end else begin
      ph      <= ph + 3'd1;
      col_adv <= 1'b0;
      case (ph)
        3'd0: begin
          fetch_q <= go;
          if (go) begin
            col_q     <= byte_addr[COL_W-1:0];
            dram_addr <= row_a;
          end
        end
        3'd1: if (fetch_q) begin
          ras_n     <= 1'b0;
          dram_addr <= col0;
        end
        3'd2: if (fetch_q) cas_n <= 1'b0;
        3'd3: if (fetch_q) hi_q <= dram_nibble;
        3'd4: begin
          cas_n <= 1'b1;
          if (fetch_q) dram_addr <= col1;
        end
        3'd5: if (fetch_q) cas_n <= 1'b0;
        3'd6: if (fetch_q) begin
          byte_out <= {hi_q, dram_nibble};
          col_adv  <= 1'b1;
        end
        default: begin
          cas_n <= 1'b1;
          ras_n <= 1'b1;
          slot  <= half_rate ? ~slot : 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/nibble_fetch_seq_chk.sv
module nibble_fetch_seq_chk #(
  parameter int MUX_W  = 9,
  parameter int BYTE_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [MUX_W-1:0] dram_addr,
  input logic             ras_n,
  input logic             cas_n,
  input logic [BYTE_W-1:0] byte_out,
  input logic             col_adv
);
  // R10
  cas_needs_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);

  // R6
  adv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_adv |=> !col_adv);

  // R6
  adv_open_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_adv |-> (!ras_n && !cas_n));

  // R5
  byte_on_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(byte_out) |-> col_adv);

  // R4
  addr_hold_on_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $stable(dram_addr));

  // R2
  strobes_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> cas_n);
endmodule

bind nibble_fetch_seq nibble_fetch_seq_chk #(
  .MUX_W(ADDR_W - COL_W),
  .BYTE_W(2 * NIB_W)
) chk_i (
  .clk(clk),
  .rst_n(rst_n),
  .dram_addr(dram_addr),
  .ras_n(ras_n),
  .cas_n(cas_n),
  .byte_out(byte_out),
  .col_adv(col_adv)
);

// File: tb/nibble_fetch_seq_tb.sv
module nibble_fetch_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] byte_addr = '0;
  logic        fetch_win = 1'b0;
  logic        spacer = 1'b0;
  logic        half_rate = 1'b0;
  logic [3:0]  dram_nibble;
  logic [8:0]  dram_addr;
  logic        ras_n, cas_n, col_adv;
  logic [7:0]  byte_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nibble_fetch_seq dut_i (
    .clk(clk), .rst_n(rst_n), .byte_addr(byte_addr), .fetch_win(fetch_win),
    .spacer(spacer), .half_rate(half_rate), .dram_nibble(dram_nibble),
    .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n),
    .byte_out(byte_out), .col_adv(col_adv)
  );

  function automatic logic [3:0] nib(input logic [16:0] n);
    return 4'(n[3:0] + n[7:4] * 4'd3 + n[11:8] * 4'd5 + n[15:12] + {3'b0, n[16]});
  endfunction

  logic [8:0] row_l = '0, col_l = '0, addr_prev = '0;
  logic       ras_prev = 1'b1, cas_prev = 1'b1;
  assign dram_nibble = nib({row_l, col_l[7:0]});

  always @(negedge clk) begin
    if (!ras_n && ras_prev) row_l = addr_prev;
    if (!cas_n && cas_prev) col_l = addr_prev;
    ras_prev  = ras_n;
    cas_prev  = cas_n;
    addr_prev = dram_addr;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [7:0] exp_byte = '0;
  bit         slot_m = 1'b0;

  task automatic run_slot(input logic [15:0] a, input bit win, input bit sp, input bit half);
    bit f;
    logic [7:0] nb;
    byte_addr = a; fetch_win = win; spacer = sp; half_rate = half;
    f  = win && !sp && !slot_m;
    nb = {nib({a, 1'b0}), nib({a, 1'b1})};
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == 0) begin
        byte_addr = ~a; fetch_win = ~win; spacer = ~sp;
      end
      if (f) begin
        chk("R2 ras", 16'(ras_n), 16'(!(k >= 1 && k <= 6)));
        chk("R2 cas", 16'(cas_n), 16'(!(k == 2 || k == 3 || k == 5 || k == 6)));
        if (k == 0) chk("R3 row", 16'(dram_addr), 16'(a[15:7]));
        else if (k <= 3) chk("R4 col0", 16'(dram_addr), 16'({a[6:0], 1'b0}));
        else chk("R4 col1", 16'(dram_addr), 16'({a[6:0], 1'b1}));
        chk("R6 adv", 16'(col_adv), 16'(k == 6));
        chk("R5 byte", 16'(byte_out), 16'(k >= 6 ? nb : exp_byte));
      end else begin
        chk("R9 strobes", 16'({ras_n, cas_n, col_adv}), 16'(3'b110));
        chk("R9 byte", 16'(byte_out), 16'(exp_byte));
      end
      if (k == 1) chk(half ? "R8 decision" : "R7 decision", 16'(ras_n), 16'(!f));
    end
    if (f) exp_byte = nb;
    slot_m = half ? ~slot_m : 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset", {ras_n, cas_n, col_adv, 13'(dram_addr)}, 16'hc000);
    chk("R1 reset byte", 16'(byte_out), 16'h0);
    rst_n = 1'b1;
    for (int p = 0; p < 640; p++) begin
      logic [15:0] a;
      a = 16'(p * 16'h00a3 + 16'h1357) ^ 16'(p << 9);
      run_slot(a, (p % 5) != 3, (p % 7) == 4, ((p / 40) % 2) == 1);
    end
    for (int p = 0; p < 6; p++) run_slot(16'hffff - 16'(p), 1'b1, 1'b0, 1'b1);
    run_slot(16'h0000, 1'b1, 1'b0, 1'b0);
    run_slot(16'h7f7f, 1'b1, 1'b0, 1'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule